// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Tracker

This block keeps the single reservation used by an atomic read-modify-write pair in a data cache pipeline. A load-with-reservation request records the line address it touched. A later conditional store to the same line is allowed to go on to memory. If there is no reservation, or the reservation is for a different line, the conditional store is cancelled. A cancelled store finishes early with a failure and never starts a bus cycle. Reservations are compared at cache-line granularity: every address bit above the line-offset field must match, and the offset bits are ignored. The reservation changes only on the final part of a multi-part atomic access.

Each request is captured in a stage register. The decision is made in the next cycle from that register, and any change to the reservation takes effect at the end of that cycle. A small completion state machine then reports the outcome, and it has four states:
- `ST_IDLE`: waits for a store in the stage register.
- `ST_WAIT_ACK`: a permitted store has been handed downstream through `store_go` and the block waits for `store_ack`.
- `ST_FAIL_DONE`: reports a cancelled conditional store.
- `ST_PASS_DONE`: reports a store that memory accepted.

The transitions are:
- `ST_IDLE` to `ST_FAIL_DONE` when the staged store is cancelled.
- `ST_IDLE` to `ST_WAIT_ACK` when the staged store may proceed.
- `ST_WAIT_ACK` to `ST_PASS_DONE` on `store_ack`.
- `ST_FAIL_DONE` and `ST_PASS_DONE` back to `ST_IDLE` unconditionally.

Top module: `lsr_tracker`

## Requirements
- R1: During and after reset, the reservation is invalid, `done_valid` and `store_go` are low, and `store_done` is high. A conditional store issued right after reset therefore fails.
- R2: A request with `req_load`=1 and `req_rsv`=1 sets the reservation to its line address (bits 63 down to 6 with a 64-byte line) only when `req_last`=1. With `req_last`=0 the reservation is left unchanged. A new setting replaces the previous line.
- R3: A conditional store (`req_store`=1, `req_rsv`=1) clears the reservation only when `req_last`=1, whether it succeeds or fails. With `req_last`=0 the reservation is left unchanged.
- R4: A conditional store is cancelled when the reservation is invalid or when any address bit at or above bit 6 differs from the stored line. Differences in bits 5..0 do not cancel it.
- R5: A request presented in cycle 0 and cancelled gives `done_valid`=1 with `store_done`=0 in cycle 2. `store_go` is never raised for it.
- R6: A store that is not cancelled (conditional with a matching reservation, or a plain store with `req_rsv`=0) raises `store_go` for exactly cycle 1. `done_valid`=1 with `store_done`=1 follows in the cycle after `store_ack`.
- R7: `store_done` is the inverse of a one-cycle fail flag. It is low only in the failure-report cycle, and a failure report never coincides with a success report.
- R8: A request carrying both `req_load` and `req_store` with `req_rsv`=1 and `req_last`=1 is completed as a conditional store. Its clear beats its set, so the reservation ends up invalid.
- R9: Plain loads and plain stores (`req_rsv`=0) leave the reservation unchanged.
- R10: `store_ack` is ignored while no store is awaiting acknowledgement. It produces no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_load | input | 1 | Request is a load |
| req_store | input | 1 | Request is a store |
| req_rsv | input | 1 | Reservation-type request (load-reserve or conditional store) |
| req_last | input | 1 | Final part of a multi-part atomic access |
| req_addr | input | ADDR_W (64) | Effective address of the request |
| store_ack | input | 1 | Downstream memory finished the store it was handed |
| store_go | output | 1 | Store may proceed downstream (one-cycle pulse) |
| done_valid | output | 1 | Store completion pulse |
| store_done | output | 1 | Store-done status, inverse of the fail flag |

## Verification
The assertions assume that a store is only presented while the completion machine is in `ST_IDLE` and no other store is outstanding. They also assume that `store_ack` arrives at most once for each `store_go`. Under these conditions a cancellation and an acknowledgement can never fall in the same cycle. The bench follows these rules by running each store through to its completion and the idle cycle after it before it issues the next request. It raises `store_ack` only in the waiting cycle, apart from the one deliberate stray acknowledgement sent while the block is idle. Loads are issued only between stores, so the reservation is always probed by a conditional store that starts from idle.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_ACK  = 2'd1,
        ST_FAIL_DONE = 2'd2,
        ST_PASS_DONE = 2'd3
    } ctl_state_e;

    typedef struct packed {
        logic vld;
        logic load;
        logic store;
        logic rsv;
        logic last;
    } req_flags_t;

endpackage

// File: rtl/lsr_req_stage.sv
module lsr_req_stage
    import lsr_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  req_flags_t        in_flags,
    input  logic [ADDR_W-1:0] in_addr,
    output req_flags_t        st_flags,
    output logic [ADDR_W-1:0] st_addr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_flags <= '0;
            st_addr  <= '0;
        end else begin
            st_flags <= in_flags;
            if (in_flags.vld) begin
                st_addr <= in_addr;
            end
        end
    end

endmodule

// File: rtl/lsr_rsv_track.sv
module lsr_rsv_track
    import lsr_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int LINE_OFF_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  req_flags_t        st_flags,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              set_req,
    output logic              clr_req,
    output logic              cancel,
    output logic              rsv_valid
);

    localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << LINE_OFF_W) - ADDR_W'(1));

    logic [ADDR_W-1:0] rsv_line_q;
    logic [ADDR_W-1:0] st_line;
    logic              is_lr;
    logic              is_sc;
    logic              line_hit;

    always_comb begin
        st_line  = st_addr & LINE_MASK;
        is_lr    = st_flags.vld & st_flags.load & st_flags.rsv;
        is_sc    = st_flags.vld & st_flags.store & st_flags.rsv;
        line_hit = (st_line == rsv_line_q);
        set_req  = is_lr & st_flags.last;
        clr_req  = is_sc & st_flags.last;
        cancel   = is_sc & (~rsv_valid | ~line_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsv_valid  <= 1'b0;
            rsv_line_q <= '0;
        end else if (clr_req) begin
            rsv_valid <= 1'b0;
        end else if (set_req) begin
            rsv_valid  <= 1'b1;
            rsv_line_q <= st_line;
        end
    end

endmodule

// File: rtl/lsr_cmpl_fsm.sv
module lsr_cmpl_fsm
    import lsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stage_store,
    input  logic cancel,
    input  logic store_ack,
    output logic store_go,
    output logic done_valid,
    output logic store_done
);

    ctl_state_e state_q;
    ctl_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (stage_store) begin
                    state_d = cancel ? ST_FAIL_DONE : ST_WAIT_ACK;
                end
            end
            ST_WAIT_ACK: begin
                if (store_ack) begin
                    state_d = ST_PASS_DONE;
                end
            end
            ST_FAIL_DONE: state_d = ST_IDLE;
            ST_PASS_DONE: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        store_go   = 1'b0;
        done_valid = 1'b0;
        store_done = 1'b1;
        unique case (state_q)
            ST_IDLE:      store_go = stage_store & ~cancel;
            ST_WAIT_ACK:  store_go = 1'b0;
            ST_FAIL_DONE: begin
                done_valid = 1'b1;
                store_done = 1'b0;
            end
            ST_PASS_DONE: done_valid = 1'b1;
            default:      store_go = 1'b0;
        endcase
    end

endmodule

// File: rtl/lsr_tracker.sv
module lsr_tracker
    import lsr_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_load,
    input  logic              req_store,
    input  logic              req_rsv,
    input  logic              req_last,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              store_ack,
    output logic              store_go,
    output logic              done_valid,
    output logic              store_done
);

    localparam int LINE_OFF_W = $clog2(LINE_BYTES);

    req_flags_t        in_flags;
    req_flags_t        st_flags;
    logic [ADDR_W-1:0] st_addr;
    logic              set_req;
    logic              clr_req;
    logic              cancel;
    logic              rsv_valid;
    logic              stage_store;

    always_comb begin
        in_flags.vld   = req_valid;
        in_flags.load  = req_valid & req_load;
        in_flags.store = req_valid & req_store;
        in_flags.rsv   = req_valid & req_rsv;
        in_flags.last  = req_valid & req_last;
        stage_store    = st_flags.vld & st_flags.store;
    end

    lsr_req_stage #(.ADDR_W(ADDR_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_flags (in_flags),
        .in_addr  (req_addr),
        .st_flags (st_flags),
        .st_addr  (st_addr)
    );

    lsr_rsv_track #(.ADDR_W(ADDR_W), .LINE_OFF_W(LINE_OFF_W)) u_rsv (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_flags  (st_flags),
        .st_addr   (st_addr),
        .set_req   (set_req),
        .clr_req   (clr_req),
        .cancel    (cancel),
        .rsv_valid (rsv_valid)
    );

    lsr_cmpl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stage_store (stage_store),
        .cancel      (cancel),
        .store_ack   (store_ack),
        .store_go    (store_go),
        .done_valid  (done_valid),
        .store_done  (store_done)
    );

endmodule

// File: rtl/lsr_tracker_checker.sv
module lsr_tracker_checker (
    input logic clk,
    input logic rst_n,
    input logic rsv_valid,
    input logic set_req,
    input logic clr_req,
    input logic cancel,
    input logic stage_store,
    input logic store_ack,
    input logic store_go,
    input logic done_valid,
    input logic store_done
);

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rsv_valid); // R1

    AST_SET_NEEDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsv_valid) |-> $past(set_req)); // R2

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> !rsv_valid); // R3 R8

    AST_CANCEL_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |-> !store_go); // R4

    AST_FAIL_FROM_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !store_done) |-> $past(cancel)); // R5

    AST_GO_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        store_go |-> stage_store); // R6

    AST_PASS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && store_done) |-> $past(store_ack)); // R6

    AST_FAIL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !store_done) |=> store_done); // R7

    AST_DONE_ONLY_WHEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !store_done |-> done_valid); // R7

endmodule

bind lsr_tracker lsr_tracker_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rsv_valid   (rsv_valid),
    .set_req     (set_req),
    .clr_req     (clr_req),
    .cancel      (cancel),
    .stage_store (stage_store),
    .store_ack   (store_ack),
    .store_go    (store_go),
    .done_valid  (done_valid),
    .store_done  (store_done)
);

// File: tb/lsr_tracker_bench.sv
module lsr_tracker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_load = 1'b0;
    logic        req_store = 1'b0;
    logic        req_rsv = 1'b0;
    logic        req_last = 1'b0;
    logic [63:0] req_addr = '0;
    logic        store_ack = 1'b0;
    logic        store_go;
    logic        done_valid;
    logic        store_done;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    localparam logic [63:0] ADDR_A = 64'h0000_1234_5678_9A40;
    localparam logic [63:0] ADDR_B = 64'h0000_0000_0000_2000;

    always #5 clk = ~clk;

    lsr_tracker u_lsr_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_load   (req_load),
        .req_store  (req_store),
        .req_rsv    (req_rsv),
        .req_last   (req_last),
        .req_addr   (req_addr),
        .store_ack  (store_ack),
        .store_go   (store_go),
        .done_valid (done_valid),
        .store_done (store_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [2:0] act, input logic [2:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // {store_go, done_valid, store_done}
    task automatic check_outs(input string req, input string what, input logic [2:0] exp);
        logic [2:0] act;
        act = {store_go, done_valid, store_done};
        check(act === exp, req, what, act, exp);
    endtask

    // present one request for a single cycle; returns at the cycle-1 negedge
    task automatic send(input bit ld, input bit st, input bit rsv, input bit last,
                        input logic [63:0] addr);
        req_valid = 1'b1;
        req_load  = ld;
        req_store = st;
        req_rsv   = rsv;
        req_last  = last;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
        req_load  = 1'b0;
        req_store = 1'b0;
        req_rsv   = 1'b0;
        req_last  = 1'b0;
    endtask

    task automatic do_load(input bit rsv, input bit last, input logic [63:0] addr);
        send(1'b1, 1'b0, rsv, last, addr);
        @(negedge clk);
    endtask

    // run any store to completion and check the whole sequence
    task automatic do_store(input bit ld, input bit rsv, input bit last,
                            input logic [63:0] addr, input bit exp_ok, input string req);
        send(ld, 1'b1, rsv, last, addr);
        if (exp_ok) begin
            check_outs("R6", {req, " go in cycle 1"}, 3'b101);
            @(negedge clk);
            check_outs("R6", {req, " waiting for ack"}, 3'b001);
            store_ack = 1'b1;
            @(negedge clk);
            store_ack = 1'b0;
            check_outs("R6", {req, " pass completion"}, 3'b011);
        end else begin
            check_outs("R5", {req, " no go when cancelled"}, 3'b001);
            @(negedge clk);
            check_outs("R5", {req, " fail completion in cycle 2"}, 3'b010);
        end
        @(negedge clk);
        check_outs("R7", {req, " completion is one cycle"}, 3'b001);
    endtask

    task automatic t_reset;
        check_outs("R1", "outputs in reset", 3'b001);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_outs("R1", "outputs after reset", 3'b001);
        do_store(1'b0, 1'b1, 1'b0, ADDR_A, 1'b0, "R1 sc after reset");
        do_load(1'b1, 1'b1, ADDR_A);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        do_store(1'b0, 1'b1, 1'b0, ADDR_A, 1'b0, "R1 reset drops reservation");
    endtask

    task automatic t_set;
        do_load(1'b1, 1'b0, ADDR_A);
        do_store(1'b0, 1'b1, 1'b0, ADDR_A, 1'b0, "R2 lr without last");
        do_load(1'b1, 1'b1, ADDR_A);
        do_store(1'b0, 1'b1, 1'b0, ADDR_A, 1'b1, "R2 lr with last");
        do_load(1'b1, 1'b1, ADDR_B);
        do_store(1'b0, 1'b1, 1'b0, ADDR_A, 1'b0, "R2 old line replaced");
        do_store(1'b0, 1'b1, 1'b0, ADDR_B, 1'b1, "R2 new line held");
    endtask

    task automatic t_granule;
        do_load(1'b1, 1'b1, ADDR_A);
        do_store(1'b0, 1'b1, 1'b0, ADDR_A + 64'h3F - 64'h0, 1'b1, "R4 offset bits ignored");
        do_store(1'b0, 1'b1, 1'b0, ADDR_A + 64'h40, 1'b0, "R4 next line");
        do_store(1'b0, 1'b1, 1'b0, ADDR_A ^ (64'h1 << 63), 1'b0, "R4 top bit differs");
        do_store(1'b0, 1'b1, 1'b0, ADDR_A ^ 64'h1F, 1'b1, "R4 low bits flipped");
    endtask

    task automatic t_clear;
        do_load(1'b1, 1'b1, ADDR_A);
        do_store(1'b0, 1'b1, 1'b0, ADDR_A, 1'b1, "R3 sc without last");
        do_store(1'b0, 1'b1, 1'b1, ADDR_A, 1'b1, "R3 sc with last");
        do_store(1'b0, 1'b1, 1'b0, ADDR_A, 1'b0, "R3 cleared after success");
        do_load(1'b1, 1'b1, ADDR_A);
        do_store(1'b0, 1'b1, 1'b1, ADDR_B, 1'b0, "R3 failing sc with last");
        do_store(1'b0, 1'b1, 1'b0, ADDR_A, 1'b0, "R3 cleared after failure");
    endtask

    task automatic t_plain;
        do_load(1'b1, 1'b1, ADDR_A);
        do_load(1'b0, 1'b1, ADDR_B);
        do_store(1'b0, 1'b0, 1'b1, ADDR_B, 1'b1, "R9 plain store");
        do_store(1'b0, 1'b0, 1'b1, ADDR_A, 1'b1, "R9 plain store same line");
        do_store(1'b0, 1'b1, 1'b0, ADDR_A, 1'b1, "R9 reservation kept");
    endtask

    task automatic t_both;
        do_load(1'b1, 1'b1, ADDR_A);
        do_store(1'b1, 1'b1, 1'b1, ADDR_A, 1'b1, "R8 load and store together");
        do_store(1'b0, 1'b1, 1'b0, ADDR_A, 1'b0, "R8 clear beats set");
    endtask

    task automatic t_stray_ack;
        store_ack = 1'b1;
        @(negedge clk);
        store_ack = 1'b0;
        check_outs("R10", "stray ack, cycle after", 3'b001);
        @(negedge clk);
        check_outs("R10", "stray ack, two cycles after", 3'b001);
        do_store(1'b0, 1'b1, 1'b0, ADDR_B, 1'b0, "R10 state unchanged");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_set();
        t_granule();
        t_clear();
        t_plain();
        t_both();
        t_stray_ack();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule